// File: doc/BRIEF.md
# Column-Major Sliding Window Generator

This block builds the square pixel neighbourhood that a shift-variant 2-D convolver needs around each pixel of interest. The window is N pixels on a side, where N = 2S+1 and S is the number of rows above and below the centre pixel. The default is S = 2, which gives a 5x5 window. Image data arrives as raster micro-rows. Each micro-row is one burst of bus-wide words, and the words are written into one half of an on-chip ping-pong tile buffer, with N rows to a tile. While one half fills, the other half drains into the window.

Draining walks the tile one column at a time and, within a column, from the top row to the bottom row. Each clock reads one bus-wide word into a holding register. A lane multiplexer then picks the single pixel that belongs to the current column and shifts it into an NxN register chain. After a column has been fully shifted in, the window has moved one column to the right. A strobe then marks that the window is ready, once at least N columns have been collected. The window keeps moving across tile boundaries, so successive tiles behave as one continuous horizontal stream.

Top module: `swm_window_gen`

## Requirements
- R1: While reset is held and just after it, `win_valid` is 0 and `wr_ready` is 1.
- R2: A write of row `wr_row` and word `wr_word` stores one bus word. Its pixel lane p (bits p*PIX_W upward) is tile column `wr_word*WORD_PIX + p`, so lane 0 is the leftmost pixel.
- R3: A tile is drained one pixel per clock, column by column from left to right and top row to bottom row within a column. A column whose neighbour lies in the next bus word continues into that word with no gap.
- R4: In `win_pix`, the pixel at window row r (0 = top) and window column j (0 = leftmost, oldest) occupies bits starting at (r*N + j)*PIX_W.
- R5: `win_valid` is high for exactly one clock after each column is completed, starting with the N-th column since reset. Its window then covers the last N columns, so a stream of C columns gives C-N+1 windows.
- R6: While a tile is being drained, consecutive `win_valid` pulses are exactly N clocks apart, and no two pulses are ever closer than N clocks.
- R7: An accepted `wr_tile_done` marks the half being filled as complete and moves filling to the other half. Draining alternates between halves, and the window content runs on seamlessly from one tile into the next.
- R8: When no complete tile is waiting, draining stalls: no pixel is shifted and `win_valid` stays low until a tile is completed.
- R9: `wr_ready` is low exactly when both halves hold complete tiles. While it is low, `wr_en` and `wr_tile_done` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one bus word into the half being filled |
| wr_row | input | $clog2(N) | Tile row of the written word (0..N-1) |
| wr_word | input | $clog2(BURST_WORDS) | Word position within the burst |
| wr_data | input | WORD_PIX*PIX_W | Bus word, lane 0 in the low bits |
| wr_tile_done | input | 1 | Current fill half is complete |
| wr_ready | output | 1 | Fill half is free to accept writes |
| win_valid | output | 1 | One-clock strobe: a new window position is ready |
| win_pix | output | N*N*PIX_W | Window pixels, row-major by (row, column) |

## Verification
The bench streams six tiles of random pixels and compares every window against one assembled from its own image model. A wrong lane order, row order, word step at a lane boundary or chain orientation would show up as a scrambled window. Within a tile, the spacing between strobes must be exactly N clocks; an off-by-one column counter would give an early, a missing or a doubled strobe. A garbage write and a tile-done pulse are driven while both halves are full. They must leave the tile being drained untouched, so the windows taken from that tile show whether they were ignored. A pause with both halves empty checks that the strobe stays silent. A final count of C-N+1 windows catches a fill counter that starts too early or wraps.

// File: rtl/swm_pkg.sv
package swm_pkg;

    localparam int unsigned DEF_S           = 2;
    localparam int unsigned DEF_PIX_W       = 8;
    localparam int unsigned DEF_WORD_PIX    = 8;
    localparam int unsigned DEF_BURST_WORDS = 4;

    // index width that never collapses to zero bits
    function automatic int unsigned idx_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/swm_tile_buf.sv
module swm_tile_buf #(
    parameter int unsigned ROWS   = 5,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned WORD_W = 64
) (
    input  logic                                 clk,
    input  logic                                 we,
    input  logic                                 wr_half,
    input  logic [swm_pkg::idx_w(ROWS)-1:0]      wr_row,
    input  logic [swm_pkg::idx_w(WORDS)-1:0]     wr_word,
    input  logic [WORD_W-1:0]                    wr_data,
    input  logic                                 rd_half,
    input  logic [swm_pkg::idx_w(ROWS)-1:0]      rd_row,
    input  logic [swm_pkg::idx_w(WORDS)-1:0]     rd_word,
    output logic [WORD_W-1:0]                    rd_data
);

    logic [WORD_W-1:0] mem_q [2][ROWS][WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[wr_half][wr_row][wr_word] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_half][rd_row][rd_word];

endmodule

// File: rtl/swm_pingpong_ctrl.sv
module swm_pingpong_ctrl #(
    parameter int unsigned ROWS     = 5,
    parameter int unsigned WORDS    = 4,
    parameter int unsigned WORD_PIX = 8,
    localparam int unsigned COLS    = WORDS * WORD_PIX,
    localparam int unsigned RW      = swm_pkg::idx_w(ROWS),
    localparam int unsigned CW      = swm_pkg::idx_w(COLS),
    localparam int unsigned LW      = swm_pkg::idx_w(WORD_PIX),
    localparam int unsigned WW      = CW - LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_tile_done,
    output logic          wr_ready,
    output logic          we,
    output logic          fill_half,
    output logic          rd_issue,
    output logic          rd_half,
    output logic [RW-1:0] rd_row,
    output logic [WW-1:0] rd_word,
    output logic [LW-1:0] rd_lane,
    output logic          rd_last_row,
    output logic [1:0]    full_flags
);

    typedef struct packed {
        logic [1:0]    full;
        logic          fill;
        logic          drain;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        rd_issue = st_q.full[st_q.drain];
        wr_ready = !st_q.full[st_q.fill];
        we       = wr_en && wr_ready;

        if (rd_issue) begin
            if (st_q.row == RW'(ROWS - 1)) begin
                st_d.row = '0;
                if (st_q.col == CW'(COLS - 1)) begin
                    st_d.col                = '0;
                    st_d.full[st_q.drain]   = 1'b0;
                    st_d.drain              = ~st_q.drain;
                end else begin
                    st_d.col = st_q.col + 1'b1;
                end
            end else begin
                st_d.row = st_q.row + 1'b1;
            end
        end

        if (wr_tile_done && wr_ready) begin
            st_d.full[st_q.fill] = 1'b1;
            st_d.fill            = ~st_q.fill;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fill_half   = st_q.fill;
    assign rd_half     = st_q.drain;
    assign rd_row      = st_q.row;
    assign rd_word     = st_q.col[CW-1:LW];
    assign rd_lane     = st_q.col[LW-1:0];
    assign rd_last_row = (st_q.row == RW'(ROWS - 1));
    assign full_flags  = st_q.full;

endmodule

// File: rtl/swm_window_array.sv
module swm_window_array #(
    parameter int unsigned N        = 5,
    parameter int unsigned PIX_W    = 8,
    parameter int unsigned WORD_PIX = 8,
    localparam int unsigned WORD_W  = PIX_W * WORD_PIX,
    localparam int unsigned NN      = N * N,
    localparam int unsigned LW      = swm_pkg::idx_w(WORD_PIX),
    localparam int unsigned CNTW    = swm_pkg::idx_w(N + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_issue,
    input  logic [WORD_W-1:0]          rd_data,
    input  logic [LW-1:0]              rd_lane,
    input  logic                       rd_last_row,
    output logic                       shift_en,
    output logic                       win_valid,
    output logic [NN-1:0][PIX_W-1:0]   chain
);

    typedef struct packed {
        logic [WORD_W-1:0]         word;
        logic [LW-1:0]             lane;
        logic                      v;
        logic                      last;
        logic [NN-1:0][PIX_W-1:0]  chain;
        logic [CNTW-1:0]           cnt;
        logic                      valid;
    } arr_t;

    arr_t st_d, st_q;
    logic [PIX_W-1:0] pix_sel;

    always_comb begin
        st_d       = st_q;
        st_d.word  = rd_data;
        st_d.lane  = rd_lane;
        st_d.v     = rd_issue;
        st_d.last  = rd_last_row;
        st_d.valid = 1'b0;
        pix_sel    = st_q.word[st_q.lane * PIX_W +: PIX_W];

        if (st_q.v) begin
            for (int i = 0; i < NN - 1; i++) begin
                st_d.chain[i] = st_q.chain[i + 1];
            end
            st_d.chain[NN-1] = pix_sel;
            if (st_q.last) begin
                st_d.valid = (st_q.cnt >= CNTW'(N - 1));
                if (st_q.cnt < CNTW'(N)) st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shift_en  = st_q.v;
    assign win_valid = st_q.valid;
    assign chain     = st_q.chain;

endmodule

// File: rtl/swm_window_gen.sv
module swm_window_gen #(
    parameter int unsigned S           = swm_pkg::DEF_S,
    parameter int unsigned PIX_W       = swm_pkg::DEF_PIX_W,
    parameter int unsigned WORD_PIX    = swm_pkg::DEF_WORD_PIX,
    parameter int unsigned BURST_WORDS = swm_pkg::DEF_BURST_WORDS,
    localparam int unsigned N          = 2 * S + 1,
    localparam int unsigned WORD_W     = PIX_W * WORD_PIX,
    localparam int unsigned RW         = swm_pkg::idx_w(N),
    localparam int unsigned WW         = swm_pkg::idx_w(BURST_WORDS),
    localparam int unsigned LW         = swm_pkg::idx_w(WORD_PIX)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [RW-1:0]          wr_row,
    input  logic [WW-1:0]          wr_word,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic                   wr_tile_done,
    output logic                   wr_ready,
    output logic                   win_valid,
    output logic [N*N*PIX_W-1:0]   win_pix
);

    logic                         we_w;
    logic                         fill_w;
    logic                         rd_issue_w;
    logic                         rd_half_w;
    logic [RW-1:0]                rd_row_w;
    logic [WW-1:0]                rd_word_w;
    logic [LW-1:0]                rd_lane_w;
    logic                         rd_last_w;
    logic [1:0]                   full_w;
    logic [WORD_W-1:0]            rd_data_w;
    logic                         shift_en_w;
    logic [N*N-1:0][PIX_W-1:0]    chain_w;

    swm_pingpong_ctrl #(
        .ROWS(N), .WORDS(BURST_WORDS), .WORD_PIX(WORD_PIX)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_tile_done(wr_tile_done), .wr_ready(wr_ready),
        .we(we_w), .fill_half(fill_w),
        .rd_issue(rd_issue_w), .rd_half(rd_half_w), .rd_row(rd_row_w),
        .rd_word(rd_word_w), .rd_lane(rd_lane_w), .rd_last_row(rd_last_w),
        .full_flags(full_w)
    );

    swm_tile_buf #(
        .ROWS(N), .WORDS(BURST_WORDS), .WORD_W(WORD_W)
    ) u_buf (
        .clk(clk), .we(we_w), .wr_half(fill_w), .wr_row(wr_row),
        .wr_word(wr_word), .wr_data(wr_data),
        .rd_half(rd_half_w), .rd_row(rd_row_w), .rd_word(rd_word_w),
        .rd_data(rd_data_w)
    );

    swm_window_array #(
        .N(N), .PIX_W(PIX_W), .WORD_PIX(WORD_PIX)
    ) u_arr (
        .clk(clk), .rst_n(rst_n),
        .rd_issue(rd_issue_w), .rd_data(rd_data_w), .rd_lane(rd_lane_w),
        .rd_last_row(rd_last_w),
        .shift_en(shift_en_w), .win_valid(win_valid), .chain(chain_w)
    );

    // chain slot j*N+r carries window row r of column j
    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            assign win_pix[(r*N + j)*PIX_W +: PIX_W] = chain_w[j*N + r];
        end
    end

endmodule

// File: rtl/swm_checker.sv
module swm_checker #(
    parameter int unsigned N = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_tile_done,
    input logic       wr_ready,
    input logic       win_valid,
    input logic [1:0] full,
    input logic       drain_sel,
    input logic       rd_issue,
    input logic       shift_en
);

    logic [7:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (win_valid) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 8'hFF) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> !win_valid);

    p_valid_after_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> $past(shift_en));

    p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && seen_q) |-> (gap_q >= 8'(N - 1)));

    p_read_needs_tile_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |-> full[drain_sel]);

    p_done_accepted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && wr_tile_done) |=> (full != $past(full)));

    p_done_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ready && wr_tile_done) |=> ($countones(full) <= $past($countones(full))));

endmodule

bind swm_window_gen swm_checker #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_tile_done(wr_tile_done), .wr_ready(wr_ready),
    .win_valid(win_valid), .full(full_w), .drain_sel(rd_half_w),
    .rd_issue(rd_issue_w), .shift_en(shift_en_w)
);

// File: tb/swm_window_gen_tb.sv
`timescale 1ns/1ps
module swm_window_gen_tb;

    localparam int S        = 2;
    localparam int N        = 2 * S + 1;
    localparam int PIX_W    = 8;
    localparam int WORD_PIX = 8;
    localparam int WORDS    = 4;
    localparam int COLS     = WORDS * WORD_PIX;
    localparam int NT       = 6;
    localparam int TOT      = NT * COLS;
    localparam int NWIN     = TOT - N + 1;
    localparam int WORD_W   = PIX_W * WORD_PIX;
    localparam int WINW     = N * N * PIX_W;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 wr_en;
    logic [2:0]           wr_row;
    logic [1:0]           wr_word;
    logic [WORD_W-1:0]    wr_data;
    logic                 wr_tile_done;
    logic                 wr_ready;
    logic                 win_valid;
    logic [WINW-1:0]      win_pix;

    swm_window_gen #(.S(S), .PIX_W(PIX_W), .WORD_PIX(WORD_PIX), .BURST_WORDS(WORDS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_word(wr_word),
        .wr_data(wr_data), .wr_tile_done(wr_tile_done), .wr_ready(wr_ready),
        .win_valid(win_valid), .win_pix(win_pix)
    );

    always #4 clk = ~clk;

    logic [PIX_W-1:0] img [N][TOT];
    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int nwin  = 0;
    int last_cyc = 0;
    bit done  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [WINW-1:0] act,
                       input logic [WINW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] word_of(input int t, input int r, input int q);
        logic [WORD_W-1:0] w;
        for (int p = 0; p < WORD_PIX; p++)
            w[p*PIX_W +: PIX_W] = img[r][t*COLS + q*WORD_PIX + p];
        return w;
    endfunction

    function automatic logic [WINW-1:0] exp_win(input int k);
        logic [WINW-1:0] e;
        for (int r = 0; r < N; r++)
            for (int j = 0; j < N; j++)
                e[(r*N + j)*PIX_W +: PIX_W] = img[r][k + j];
        return e;
    endfunction

    task automatic write_tile(input int t);
        for (int r = 0; r < N; r++) begin
            for (int q = 0; q < WORDS; q++) begin
                @(negedge clk);
                wr_en   = 1'b1;
                wr_row  = 3'(r);
                wr_word = 2'(q);
                wr_data = word_of(t, r, q);
            end
        end
        @(negedge clk);
        wr_en        = 1'b0;
        wr_tile_done = 1'b1;
        @(negedge clk);
        wr_tile_done = 1'b0;
    endtask

    // window monitor: content (R2, R3, R4, R7) and spacing (R6)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && win_valid === 1'b1 && !done) begin
            if (nwin < NWIN) begin
                chk(win_pix === exp_win(nwin), "R2/R3/R4/R7 window content", win_pix, exp_win(nwin));
                if (nwin > 0 && ((nwin + N - 1) % COLS) != 0)
                    chk((cyc - last_cyc) == N, "R6 in-tile spacing",
                        WINW'(cyc - last_cyc), WINW'(N));
                else if (nwin > 0)
                    chk((cyc - last_cyc) >= N, "R6 cross-tile spacing",
                        WINW'(cyc - last_cyc), WINW'(N));
            end else begin
                chk(1'b0, "R5 extra window", WINW'(nwin), WINW'(NWIN - 1));
            end
            last_cyc = cyc;
            nwin++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(1'b0, "watchdog", WINW'(nwin), WINW'(NWIN));
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hold;
        void'($urandom(32'd1234));
        for (int r = 0; r < N; r++)
            for (int c = 0; c < TOT; c++)
                img[r][c] = PIX_W'($urandom);
        // directed corners: extreme values at a word seam and a tile seam
        img[0][WORD_PIX - 1] = '1;
        img[N-1][WORD_PIX]   = '0;
        img[2][COLS - 1]     = 8'hA5;
        img[2][COLS]         = 8'h5A;

        rst_n = 1'b0; wr_en = 1'b0; wr_row = '0; wr_word = '0;
        wr_data = '0; wr_tile_done = 1'b0;
        repeat (4) @(negedge clk);
        chk(win_valid === 1'b0, "R1 valid low in reset", WINW'(win_valid), '0);
        chk(wr_ready === 1'b1, "R1 ready high in reset", WINW'(wr_ready), WINW'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk(win_valid === 1'b0 && wr_ready === 1'b1, "R1 state after reset",
            WINW'({win_valid, wr_ready}), WINW'(1));

        write_tile(0);
        write_tile(1);
        chk(wr_ready === 1'b0, "R9 ready low with both halves full", WINW'(wr_ready), '0);

        // ignored write and tile-done while not ready; tile 0 is still draining
        @(negedge clk);
        wr_en = 1'b1; wr_row = '0; wr_word = '0; wr_data = '1; wr_tile_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_tile_done = 1'b0; wr_data = '0;
        chk(wr_ready === 1'b0, "R9 ignored done keeps ready low", WINW'(wr_ready), '0);

        for (int t = 2; t < 4; t++) begin
            while (wr_ready !== 1'b1) @(negedge clk);
            hold = int'($urandom % 4);
            repeat (hold) @(negedge clk);
            write_tile(t);
        end

        // stall: let all written tiles drain, then nothing must happen
        while (nwin < 4 * COLS - N + 1) @(negedge clk);
        repeat (20) @(negedge clk);
        hold = nwin;
        repeat (80) @(negedge clk);
        chk(nwin == hold, "R8 no window while stalled", WINW'(nwin), WINW'(hold));
        chk(win_valid === 1'b0, "R8 valid low while stalled", WINW'(win_valid), '0);
        chk(wr_ready === 1'b1, "R9 ready high with halves free", WINW'(wr_ready), WINW'(1));

        for (int t = 4; t < NT; t++) begin
            while (wr_ready !== 1'b1) @(negedge clk);
            write_tile(t);
        end

        while (nwin < NWIN) @(negedge clk);
        repeat (60) @(negedge clk);
        chk(nwin == NWIN, "R5 window count", WINW'(nwin), WINW'(NWIN));
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule